// File: doc/BRIEF.md
# Cascaded RAM Sample Delay Line

This block keeps the most recent input samples of a time-multiplexed FIR filter in a chain of dual-port memories instead of a register shift chain. There are four sub-memories, each 256 words of 16 bits, for a total history of 1024 samples. Every sub-memory has one registered read port and one write port. All sub-memories share the same read address, the same write address and the same write enable, and these come from an external sequencer.

Sub-memory 0 takes its write data from the `sample_in` port. Sub-memory k+1 takes its write data from the registered read output of sub-memory k. The sequencer drives the write address as the read address delayed by one clock. A word read from stage k in one cycle is then written into the same location of stage k+1 in the next cycle. Over one full sweep of 256 addresses, each stage's contents therefore move one stage down the chain.

All four read outputs are presented side by side on one bus for a downstream multiply-accumulate stage. Per-location valid bits are cleared on reset. Any location that has not been written since reset therefore reads as zero.

Top module: `sdl_delay_line`

## Requirements
- R1: Four stages of 256 x 16-bit words form a 1024-word history. A word placed in stage 0 reaches stage 3 after three full sweeps and leaves the chain after the fourth.
- R2: For the cycle after reset all taps are zero. A read of a location not written since reset returns zero.
- R3: Read latency is one clock. `taps` after clock edge t shows the words at `rd_addr` as sampled at edge t. Stage k occupies `taps[16k+15:16k]`.
- R4: When `wr_en` is 1 at an edge, stage 0 stores `sample_in` at `wr_addr`.
- R5: When `wr_en` is 1 at an edge, stage k+1 (k = 0..2) stores, at `wr_addr`, the value that stage k's tap shows in that same cycle.
- R6: All stages write at the same `wr_addr`, under the one `wr_en`.
- R7: A read and a write to the same address at the same edge return the contents from before the write.
- R8: With `wr_en` at 0, no stored word changes.
- R9: With `wr_addr` equal to `rd_addr` of the previous cycle and a sweep of all 256 addresses, stage k+1 afterwards holds what stage k held before, at the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears valid bits, blocks writes |
| rd_addr | input | 8 | Shared read address |
| wr_addr | input | 8 | Shared write address |
| wr_en | input | 1 | Shared write enable |
| sample_in | input | 16 | New sample, write data of stage 0 |
| taps | output | 64 | Registered read data of all stages, stage k at bits 16k+15:16k |

## Verification
The forwarding properties assume that the write address in one cycle points where the read address pointed in the cycle before. They check stored data only through a later read of that address. The hold property assumes that the read address stays steady across a cycle with no write. The bench mixes a long random phase with a fixed seed, in which the addresses often coincide and the enable toggles. Directed sweeps then follow the lagged address discipline exactly, so the migration of data from stage to stage can be compared against closed-form values.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    localparam int unsigned SDL_WIDTH_DEF  = 16;
    localparam int unsigned SDL_DEPTH_DEF  = 256;
    localparam int unsigned SDL_STAGES_DEF = 4;

    // Source of a stage's write data
    typedef enum logic {
        WSRC_SAMPLE   = 1'b0,
        WSRC_UPSTREAM = 1'b1
    } wsrc_e;

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

    function automatic wsrc_e wsrc_of(input int unsigned stage);
        return (stage == 0) ? WSRC_SAMPLE : WSRC_UPSTREAM;
    endfunction

endpackage

// File: rtl/sdl_ram_core.sv
// Simple dual-port memory, registered read, old data on address collision.
module sdl_ram_core #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 256,
    parameter int unsigned AW    = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd,
    input  logic [AW-1:0]    ra,
    output logic [WIDTH-1:0] rq
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
        rq <= mem[ra];
    end

endmodule

// File: rtl/sdl_valid_map.sv
// One bit per location: set on write, cleared by reset; lookup registered
// alongside the memory read so both see the same (pre-write) state.
module sdl_valid_map #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned AW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [AW-1:0] set_addr,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_hit_q
);

    logic [DEPTH-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            rd_hit_q <= 1'b0;
        end else begin
            if (set_en) begin
                valid_q[set_addr] <= 1'b1;
            end
            rd_hit_q <= valid_q[rd_addr];
        end
    end

endmodule

// File: rtl/sdl_stage.sv
module sdl_stage #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 256,
    parameter int unsigned AW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd,
    input  logic [AW-1:0]    ra,
    output logic [WIDTH-1:0] tap
);

    logic [WIDTH-1:0] raw_q;
    logic             hit_q;

    sdl_ram_core #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk (clk),
        .we  (we),
        .wa  (wa),
        .wd  (wd),
        .ra  (ra),
        .rq  (raw_q)
    );

    sdl_valid_map #(.DEPTH(DEPTH), .AW(AW)) u_vld (
        .clk      (clk),
        .rst      (rst),
        .set_en   (we),
        .set_addr (wa),
        .rd_addr  (ra),
        .rd_hit_q (hit_q)
    );

    assign tap = hit_q ? raw_q : '0;

endmodule

// File: rtl/sdl_delay_line.sv
module sdl_delay_line
    import sdl_pkg::*;
#(
    parameter int unsigned WIDTH  = SDL_WIDTH_DEF,
    parameter int unsigned DEPTH  = SDL_DEPTH_DEF,
    parameter int unsigned STAGES = SDL_STAGES_DEF,
    localparam int unsigned AW    = addr_bits(DEPTH),
    localparam int unsigned TW    = WIDTH * STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_addr,
    input  logic [AW-1:0]    wr_addr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] sample_in,
    output logic [TW-1:0]    taps
);

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
    } wr_cmd_t;

    wr_cmd_t          wcmd;
    logic [WIDTH-1:0] tap_w [STAGES];
    logic [WIDTH-1:0] wdat  [STAGES];

    // Writes are blocked while reset is held
    assign wcmd = '{en: wr_en & ~rst, addr: wr_addr};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (wsrc_of(g) == WSRC_SAMPLE) begin : g_head
            assign wdat[g] = sample_in;
        end else begin : g_link
            assign wdat[g] = tap_w[g-1];
        end

        sdl_stage #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_stage (
            .clk (clk),
            .rst (rst),
            .we  (wcmd.en),
            .wa  (wcmd.addr),
            .wd  (wdat[g]),
            .ra  (rd_addr),
            .tap (tap_w[g])
        );

        assign taps[g*WIDTH +: WIDTH] = tap_w[g];
    end

endmodule

// File: rtl/sdl_delay_line_chk.sv
module sdl_delay_line_chk #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 4,
    parameter int unsigned AW     = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic [AW-1:0]           rd_addr,
    input logic [AW-1:0]           wr_addr,
    input logic                    wr_en,
    input logic [WIDTH-1:0]        sample_in,
    input logic [WIDTH*STAGES-1:0] taps
);

    // Cycles since reset, saturating
    logic [1:0] cyc_q;
    always_ff @(posedge clk) begin
        if (rst)                cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == 2'd0) |-> (taps == '0)); // R2

    AST_HEAD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cyc_q != 2'd0 && $past(wr_en) && rd_addr == $past(wr_addr))
        |=> (taps[WIDTH-1:0] == $past(sample_in, 2))); // R4

    for (genvar k = 1; k < STAGES; k++) begin : g_fwd
        AST_CHAIN_FWD: assert property (@(posedge clk) disable iff (rst)
            (cyc_q != 2'd0 && $past(wr_en) && rd_addr == $past(wr_addr))
            |=> (taps[k*WIDTH +: WIDTH] == $past(taps[(k-1)*WIDTH +: WIDTH], 2))); // R5
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cyc_q != 2'd0 && !$past(wr_en) && $stable(rd_addr))
        |=> $stable(taps)); // R8

endmodule

bind sdl_delay_line sdl_delay_line_chk #(
    .WIDTH(WIDTH), .STAGES(STAGES), .AW(AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_addr   (rd_addr),
    .wr_addr   (wr_addr),
    .wr_en     (wr_en),
    .sample_in (sample_in),
    .taps      (taps)
);

// File: tb/sdl_delay_line_test.sv
`timescale 1ns/1ps
module sdl_delay_line_test;

    localparam int W  = 16;
    localparam int D  = 256;
    localparam int S  = 4;
    localparam int AW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [AW-1:0]   rd_addr = '0;
    logic [AW-1:0]   wr_addr = '0;
    logic            wr_en = 1'b0;
    logic [W-1:0]    sample_in = '0;
    logic [W*S-1:0]  taps;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [W-1:0] mdl [S][D];
    logic [W-1:0] exp_tap [S];

    always #2.5 clk = ~clk;

    sdl_delay_line uut (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .wr_addr(wr_addr),
        .wr_en(wr_en), .sample_in(sample_in), .taps(taps)
    );

    function automatic logic [W-1:0] tap_of(input int k);
        return taps[k*W +: W];
    endfunction

    function automatic logic [W-1:0] pattern(input int a);
        return W'(a * 3 + 7);
    endfunction

    // Expected effect of one clock edge with the current inputs
    task automatic model_step();
        logic [W-1:0] nxt [S];
        if (rst) begin
            for (int k = 0; k < S; k++) begin
                exp_tap[k] = '0;
                for (int a = 0; a < D; a++) mdl[k][a] = '0;
            end
        end else begin
            for (int k = 0; k < S; k++) nxt[k] = mdl[k][rd_addr];
            if (wr_en) begin
                mdl[0][wr_addr] = sample_in;
                for (int k = 1; k < S; k++) mdl[k][wr_addr] = exp_tap[k-1];
            end
            for (int k = 0; k < S; k++) exp_tap[k] = nxt[k];
        end
    endtask

    task automatic cycle(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        for (int k = 0; k < S; k++) begin
            if (tap_of(k) !== exp_tap[k]) begin
                n_bad++;
                $display("FAIL %s tap%0d actual %h expected %h", tag, k, tap_of(k), exp_tap[k]);
            end
        end
    endtask

    task automatic check_val(input string tag, input int k, input logic [W-1:0] e);
        n_vec++;
        if (tap_of(k) !== e) begin
            n_bad++;
            $display("FAIL %s tap%0d actual %h expected %h", tag, k, tap_of(k), e);
        end
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i <= D; i++) begin
            rd_addr   = AW'(i % D);
            wr_addr   = AW'(i - 1);
            wr_en     = (i > 0);
            sample_in = '0;
            cycle(tag);
        end
        wr_en = 1'b0;
    endtask

    task automatic readback(input string tag, input int k, input bit expect_pat);
        wr_en = 1'b0;
        for (int a = 0; a < D; a++) begin
            rd_addr = AW'(a);
            cycle(tag);
            check_val(tag, k, expect_pat ? pattern(a) : '0);
        end
    endtask

    initial begin
        void'($urandom(32'h5D1A_0042));
        // R2: reset state
        rst = 1'b1;
        repeat (3) cycle("R2");
        rst = 1'b0;
        for (int k = 0; k < S; k++) check_val("R2", k, '0);

        // R2: never-written locations read zero
        for (int i = 0; i < 40; i++) begin
            rd_addr = AW'($urandom);
            cycle("R2");
        end

        // R3 R4 R5 R6 R7 R8: random traffic with frequent collisions
        for (int i = 0; i < 3000; i++) begin
            rd_addr   = AW'($urandom);
            wr_addr   = ($urandom % 4 == 0) ? rd_addr : AW'($urandom);
            wr_en     = ($urandom % 4 != 0);
            sample_in = W'($urandom);
            cycle("R3 R4 R5 R6 R7 R8");
        end

        // R7: directed collision, old word returned
        wr_en = 1'b1; wr_addr = 8'd9; rd_addr = 8'd9; sample_in = 16'h1111;
        cycle("R7");
        sample_in = 16'h2222;
        cycle("R7");
        check_val("R7", 0, 16'h1111);

        // R4: fill stage 0 with a known pattern
        for (int a = 0; a < D; a++) begin
            wr_en = 1'b1; wr_addr = AW'(a); rd_addr = AW'(a); sample_in = pattern(a);
            cycle("R4");
        end
        wr_en = 1'b0;

        // R9: one lagged sweep moves stage 0 into stage 1
        sweep("R9");
        readback("R9", 1, 1'b1);
        readback("R9", 0, 1'b0);

        // R1: two more sweeps reach the last stage, a fourth drops it
        sweep("R1");
        sweep("R1");
        readback("R1", 3, 1'b1);
        sweep("R1");
        readback("R1", 3, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule